// File: doc/BRIEF.md
# APB Control and Status Register Slave

This block is an APB3 completer that places a small bank of 32-bit registers inside a 4 KB address window. The registers sit at 16-byte steps. Word 0 is a fixed identification value that software reads to confirm that the block is present. Word 1 is a read/write control word, and its value drives a 32-bit output into the fabric. Word 2 is a read-only status word that records what the most recent read transfer did.

Every transfer completes in its access phase with no wait states. Read data is driven only while a read is in its access phase. An access to any offset that has no register completes with an error response and returns zero. A write to a read-only register is dropped quietly and does not signal an error. The read counter in the status word has a parameterized width and stops at all-ones, so its saturation can be tested with a small width.

Top module: `apb_regbank`

## Requirements
- R1: `pready` is 1 in every access phase, so each transfer completes one cycle after its setup phase.
- R2: A read of offset 0x000 returns 0xDEADBEEF with `pslverr` = 0.
- R3: A write to offset 0x010 stores `pwdata` at the end of the access phase. `ctrl_out` shows the stored value from the next clock edge on, and a later read of 0x010 returns it. After reset the stored value is 0x00000000.
- R4: A write to offset 0x000 or 0x020 completes with `pslverr` = 0 and leaves both the control value and the status word unchanged.
- R5: The mapped offsets are 0x000, 0x010 and 0x020 (`paddr[11:0]`, with bits [3:0] zero). An access to any other offset has `pslverr` = 1 in its access phase. For a read, `prdata` is 0. For a write, no state changes.
- R6: Status bit 0 is 1 when the most recent read hit a mapped offset and 0 when it did not.
- R7: Status bits [11:4] hold `paddr[11:4]` of the most recent read.
- R8: Status bits [16+CNT_W-1:16] count completed reads, whether mapped or not. The count stops at all-ones. Every other status bit reads 0.
- R9: The status word is 0 after reset. A read of 0x020 returns the value from before that read's own update. Writes never change the status word.
- R10: Outside a read access phase `prdata` is 0, and outside an access phase `pslverr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset inside the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer completion, always 1 |
| pslverr | output | 1 | Error response for an unmapped offset |
| ctrl_out | output | 32 | Stored control value driven to the fabric |

## Verification
The hardest condition to reach is a saturated read counter, because at the full counter width it needs tens of thousands of reads. The bench therefore builds the block with a 5-bit counter. The random phase alone makes far more reads than 31, and a later directed burst of reads then confirms that the count field holds at all-ones and does not wrap. Offsets that are unaligned, or aligned but unmapped, are drawn at random, so the hit flag and the index field both change in ways that the mapped offsets alone would never produce.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned IDX_W   = ADDR_W - 4;
  localparam logic [DATA_W-1:0] ID_WORD = 32'hDEADBEEF;

  typedef enum logic [1:0] {
    SLOT_ID   = 2'd0,
    SLOT_CTRL = 2'd1,
    SLOT_STAT = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  // Offset -> slot; only 16-byte aligned offsets in the first three words map
  function automatic slot_e slot_of(input logic [ADDR_W-1:0] a);
    if (a[3:0] != 4'h0)              return SLOT_NONE;
    if (a[ADDR_W-1:4] == IDX_W'(0))  return SLOT_ID;
    if (a[ADDR_W-1:4] == IDX_W'(1))  return SLOT_CTRL;
    if (a[ADDR_W-1:4] == IDX_W'(2))  return SLOT_STAT;
    return SLOT_NONE;
  endfunction

  // Status layout: [31:16] count, [11:4] index, [0] hit
  function automatic logic [DATA_W-1:0] pack_status(input logic hit,
                                                    input logic [IDX_W-1:0] idx,
                                                    input logic [15:0] cnt);
    return {cnt, 4'b0000, idx, 3'b000, hit};
  endfunction
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              rd_fire,
  output logic              wr_fire,
  output logic              hit,
  output slot_e             slot
);
  logic access;

  assign access  = psel & penable;
  assign slot    = slot_of(paddr);
  assign hit     = (slot != SLOT_NONE);
  assign rd_fire = access & ~pwrite;
  assign wr_fire = access &  pwrite;
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)) else $error("control changed without a load"); // R3
endmodule

// File: rtl/regbank_status.sv
module regbank_status
  import regbank_pkg::*;
#(
  parameter int unsigned CNT_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] q
);
  logic             hit_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_full;

  assign cnt_full = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (rd_fire) begin
      hit_q <= hit;
      idx_q <= idx;
      if (!cnt_full) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q = pack_status(hit_q, idx_q, 16'(cnt_q));

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_full |=> cnt_full) else $error("read count wrapped"); // R8
  AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(q)) else $error("status moved without a read"); // R9
endmodule

// File: rtl/apb_regbank.sv
module apb_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned CNT_W = 16
)(
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output logic [31:0] ctrl_out
);
  logic              rd_fire;
  logic              wr_fire;
  logic              hit;
  slot_e             slot;
  logic              ctrl_load;
  logic [DATA_W-1:0] stat_word;

  regbank_decode u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .rd_fire (rd_fire),
    .wr_fire (wr_fire),
    .hit     (hit),
    .slot    (slot)
  );

  assign ctrl_load = wr_fire & (slot == SLOT_CTRL);

  regbank_ctrl u_ctrl (
    .clk   (pclk),
    .rst_n (presetn),
    .load  (ctrl_load),
    .din   (pwdata),
    .q     (ctrl_out)
  );

  regbank_status #(.CNT_W(CNT_W)) u_stat (
    .clk     (pclk),
    .rst_n   (presetn),
    .rd_fire (rd_fire),
    .hit     (hit),
    .idx     (paddr[ADDR_W-1:4]),
    .q       (stat_word)
  );

  always_comb begin
    prdata = '0;
    if (rd_fire) begin
      case (slot)
        SLOT_ID:   prdata = ID_WORD;
        SLOT_CTRL: prdata = ctrl_out;
        SLOT_STAT: prdata = stat_word;
        default:   prdata = '0;
      endcase
    end
  end

  assign pready  = 1'b1;
  assign pslverr = (rd_fire | wr_fire) & ~hit;

  initial begin
    assert (CNT_W >= 1 && CNT_W <= 16) else $error("CNT_W out of range");
  end

  AST_ERR_IN_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> (psel && penable)) else $error("error outside access"); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (pslverr && !pwrite) |-> (prdata == '0)) else $error("unmapped read data"); // R5
  AST_ID_CONST: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && paddr == 12'h000) |-> (prdata == 32'hDEADBEEF))
    else $error("identification word wrong"); // R2
  AST_RO_NOSTORE: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr != 12'h010) |=> $stable(ctrl_out))
    else $error("control changed by other write"); // R4
endmodule

// File: tb/apb_regbank_test.sv
`timescale 1ns/1ps
module apb_regbank_test;
  localparam int CW = 5;
  localparam int CMAX = (1 << CW) - 1;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, ctrl_out;
  logic        pready, pslverr;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_ctrl = '0;
  logic        m_hit = 1'b0;
  logic [7:0]  m_idx = '0;
  int          m_cnt = 0;

  always #2.5 pclk = ~pclk;

  apb_regbank #(.CNT_W(CW)) uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .ctrl_out(ctrl_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_mapped(input logic [11:0] a);
    return (a == 12'h000) || (a == 12'h010) || (a == 12'h020);
  endfunction

  function automatic logic [31:0] model_status();
    logic [31:0] s;
    s = 32'(m_cnt) << 16;
    s = s | (32'(m_idx) << 4);
    s = s | 32'(m_hit);
    return s;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    if (a == 12'h000) return 32'hDEADBEEF;
    if (a == 12'h010) return m_ctrl;
    if (a == 12'h020) return model_status();
    return 32'h0;
  endfunction

  // One complete transfer with all checks against the model
  task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] exp_rd;
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    #1;
    chk("R10 idle prdata", prdata, 32'h0);
    chk("R10 idle pslverr", 32'(pslverr), 32'h0);
    @(negedge pclk);
    penable = 1'b1;
    #1;
    exp_rd = wr ? 32'h0 : model_read(a);
    chk("R1 pready", 32'(pready), 32'h1);
    chk(is_mapped(a) ? "R4 no error" : "R5 error flag", 32'(pslverr), 32'(!is_mapped(a)));
    chk(wr ? "R10 write prdata" : (a == 12'h020 ? "R9 R6 R7 R8 status read" :
        (is_mapped(a) ? "R2 R3 read data" : "R5 unmapped read")), prdata, exp_rd);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
    if (wr) begin
      if (a == 12'h010) m_ctrl = d;
    end else begin
      m_hit = is_mapped(a);
      m_idx = a[11:4];
      if (m_cnt < CMAX) m_cnt++;
    end
    #1;
    chk("R3 R4 R5 ctrl_out", ctrl_out, m_ctrl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge pclk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge pclk);
    #1;
    chk("R3 reset ctrl_out", ctrl_out, 32'h0);
    chk("R10 reset pslverr", 32'(pslverr), 32'h0);
    presetn = 1'b1;

    xfer(1'b0, 12'h020, 0);            // R9 status 0 after reset
    xfer(1'b0, 12'h000, 0);            // R2
    xfer(1'b1, 12'h010, 32'h12345678); // R3
    xfer(1'b0, 12'h010, 0);
    xfer(1'b1, 12'h000, 32'hFFFFFFFF); // R4
    xfer(1'b1, 12'h020, 32'hFFFFFFFF); // R4, R9
    xfer(1'b0, 12'h020, 0);
    xfer(1'b0, 12'h014, 0);            // R5 unaligned
    xfer(1'b0, 12'h020, 0);            // R6 hit=0, R7 idx=1
    xfer(1'b1, 12'h030, 32'hA5A5A5A5); // R5 unmapped write
    xfer(1'b0, 12'hFF0, 0);            // R7 top index
    xfer(1'b0, 12'h020, 0);

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      int pick;
      pick = int'($urandom % 6);
      case (pick)
        0: a = 12'h000;
        1: a = 12'h010;
        2, 3: a = 12'h020;
        4: a = {$urandom % 256, 4'h0};
        default: a = 12'($urandom);
      endcase
      xfer(1'($urandom % 2), a, $urandom);
    end

    for (int i = 0; i < 40; i++) xfer(1'b0, 12'h000, 0);
    xfer(1'b0, 12'h020, 0);            // R8 saturated count
    chk("R8 count saturated", 32'(m_cnt), 32'(CMAX));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule